// File: doc/BRIEF.md
# Indexed Color Palette with Packed Pixel Lookup

This block holds a 256-entry color table. Each entry keeps an 8-bit red, green and blue component. A host loads it through a 16-byte register window with 32-bit writes. The host first writes an entry number to the index register. It then writes three times to the color data register, and a hidden phase counter steers those three writes to red, green and blue in turn. The index does not advance after blue, so a further triple rewrites the same entry. Reads of the window always return zero.

Next to the component table the block keeps a second table, which holds each entry already packed for the output pixel depth chosen on a 2-bit configuration input. The host can choose 3-3-2, 5-5-5, 5-6-5 or 8-8-8 packing. A pixel lookup port turns an 8-bit pixel value into the packed word with one cycle of latency. The packed copy of an entry is refreshed after every component write to that entry. When the depth input changes, an internal engine rebuilds the whole packed table at one entry per clock while `busy` is high.

After reset the same engine clears the table. It takes one entry per clock, sets every entry to black and sets entry 255 to white.

Top module: `palette_dac`

## Requirements
- R1: `bus_rdata` is zero at all times, whatever the register and whatever write traffic is in progress.
- R2: A write with `bus_word` = 0 loads the entry index from `bus_wdata[31:24]` and returns the color phase to red, even in the middle of a triple.
- R3: A write with `bus_word` = 1 stores `bus_wdata[31:24]` into the indexed entry. Phase 0 writes red, phase 1 writes green and phase 2 writes blue, and the phase then wraps back to red.
- R4: The index is not incremented after blue, so a second triple without an index write replaces the same entry and leaves its neighbours alone.
- R5: Writes with `bus_word` = 2 or 3 change no index, no phase and no table entry.
- R6: After reset `busy` is high while the table is cleared, one entry per clock. The clear ends within 300 cycles. All entries are then black except entry 255, which is white, and the index and phase are 0.
- R7: `pix_out` packs an entry according to `depth_sel`, with all bits above the packed field zero. The codes are:
  - 0 (8-bit): R[7:5] in bits [7:5], G[7:5] in bits [4:2], B[7:6] in bits [1:0].
  - 1 (15-bit): R[7:3] in bits [14:10], G[7:3] in bits [9:5], B[7:3] in bits [4:0].
  - 2 (16-bit): R[7:3] in bits [15:11], G[7:2] in bits [10:5], B[7:3] in bits [4:0].
  - 3 (32-bit): R in bits [23:16], G in bits [15:8], B in bits [7:0].
- R8: After each single component write, the packed copy of that entry shows the new component together with the entry's other two components unchanged. The new value can be looked up from the third clock edge after the write.
- R9: A change of `depth_sel` raises `busy` for 256 to 260 cycles while every packed entry is rebuilt. Afterwards all 256 entries match the new depth.
- R10: `pix_out` shows the packed entry for the `pix_idx` value sampled at the previous clock edge.
- R11: When a lookup and a packed-table update hit the same entry at the same edge, the lookup returns the old packed value. The next lookup returns the new one.
- R12: While the post-reset clear runs, color data writes are dropped and leave the phase unchanged. Index writes are still accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_word | input | 2 | Byte address bits [3:2] within the 16-byte window |
| bus_wdata | input | 32 | Write data; bits [31:24] carry index or component |
| bus_rdata | output | 32 | Read data, always zero |
| depth_sel | input | 2 | Output packing: 0=8-bit, 1=15-bit, 2=16-bit, 3=32-bit |
| pix_idx | input | 8 | Pixel value to look up |
| pix_out | output | 32 | Packed color for the pixel sampled one edge earlier |
| busy | output | 1 | Clear or full packed-table rebuild in progress |

## Verification
A color data write lands in the component table at the edge that samples it. The packed entry is read back at the next edge and written at the edge after that. A lookup therefore shows the new value only if its address is sampled at the third edge or later, and the bench leaves at least four idle cycles before it reads back. The bench holds `pix_idx` across a blue write and samples `pix_out` one, two and three edges later. This shows the old value at the same-edge collision and the new value one edge afterwards. Rebuild length is measured by counting the cycles in which `busy` is high after each depth change. Each full sweep of 256 lookups then compares each result against packing computed arithmetically in the bench.

// File: rtl/palette_dac_pkg.sv
package palette_dac_pkg;

  localparam int COMP_W = 8;
  localparam int PIX_W  = 32;

  typedef enum logic [1:0] {
    DEPTH_8  = 2'd0,
    DEPTH_15 = 2'd1,
    DEPTH_16 = 2'd2,
    DEPTH_32 = 2'd3
  } depth_e;

  typedef enum logic [1:0] {
    PH_RED   = 2'd0,
    PH_GREEN = 2'd1,
    PH_BLUE  = 2'd2
  } phase_e;

  function automatic logic [PIX_W-1:0] pack_color(
    input logic [COMP_W-1:0] r,
    input logic [COMP_W-1:0] g,
    input logic [COMP_W-1:0] b,
    input depth_e            d
  );
    logic [PIX_W-1:0] v;
    case (d)
      DEPTH_15: v = {17'd0, r[7:3], g[7:3], b[7:3]};
      DEPTH_16: v = {16'd0, r[7:3], g[7:2], b[7:3]};
      DEPTH_32: v = {8'd0, r, g, b};
      default:  v = {24'd0, r[7:5], g[7:5], b[7:6]};
    endcase
    return v;
  endfunction

endpackage

// File: rtl/palette_dac_ram.sv
module palette_dac_ram #(
  parameter int W  = 8,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];

  // read-first simple dual port: a same-edge read sees the old word
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/palette_dac_regs.sv
module palette_dac_regs
  import palette_dac_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [1:0]        bus_word,
  input  logic [31:0]       bus_wdata,
  input  logic              accept_data,
  output logic              cw_en,
  output logic [1:0]        cw_sel,
  output logic [IDX_W-1:0]  cw_idx,
  output logic [COMP_W-1:0] cw_val
);
  localparam logic [1:0] SEL_INDEX = 2'd0;
  localparam logic [1:0] SEL_DATA  = 2'd1;

  logic [IDX_W-1:0] index_q;
  phase_e           phase_q;
  logic             idx_wr;
  logic             dat_wr;
  logic             unused_low;

  assign unused_low = ^bus_wdata[23:0];

  assign idx_wr = bus_wr && (bus_word == SEL_INDEX);
  assign dat_wr = bus_wr && (bus_word == SEL_DATA) && accept_data;

  assign cw_en  = dat_wr;
  assign cw_sel = phase_q;
  assign cw_idx = index_q;
  assign cw_val = bus_wdata[31:24];

  always_ff @(posedge clk) begin
    if (rst) begin
      index_q <= '0;
      phase_q <= PH_RED;
    end else if (idx_wr) begin
      index_q <= bus_wdata[24 +: IDX_W];
      phase_q <= PH_RED;
    end else if (dat_wr) begin
      case (phase_q)
        PH_RED:   phase_q <= PH_GREEN;
        PH_GREEN: phase_q <= PH_BLUE;
        default:  phase_q <= PH_RED;
      endcase
    end
  end

  // R3: phase never reaches the unused code
  a_r3_phase_legal: assert property (@(posedge clk) disable iff (rst)
    phase_q != phase_e'(2'd3));

  // R2: index write loads index and restarts at red
  a_r2_index_load: assert property (@(posedge clk) disable iff (rst)
    idx_wr |=> (phase_q == PH_RED) && (index_q == $past(bus_wdata[24 +: IDX_W])));

  // R3: each accepted data write moves the phase one step
  a_r3_phase_step: assert property (@(posedge clk) disable iff (rst)
    dat_wr |=> (phase_q == (($past(phase_q) == PH_BLUE) ? PH_RED
                            : phase_e'($past(phase_q) + 2'd1))));

  // R5: offsets 8 and 12 disturb nothing
  a_r5_other_hold: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_word[1]) |=> ($stable(index_q) && $stable(phase_q)));

  // R12: data writes during the clear leave the phase alone
  a_r12_drop_in_clear: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && (bus_word == SEL_DATA) && !accept_data) |=> $stable(phase_q));

endmodule

// File: rtl/palette_dac_engine.sv
module palette_dac_engine
  import palette_dac_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [1:0]             depth_sel,
  input  logic                   host_we,
  input  logic [IDX_W-1:0]       host_idx,
  input  logic [2:0][COMP_W-1:0] rd_comp,
  output logic [IDX_W-1:0]       comp_raddr,
  output logic                   init_active,
  output logic [IDX_W-1:0]       init_addr,
  output logic [COMP_W-1:0]      init_val,
  output logic                   pk_we,
  output logic [IDX_W-1:0]       pk_waddr,
  output logic [PIX_W-1:0]       pk_wdata,
  output logic                   busy
);
  localparam logic [IDX_W-1:0] LAST = '1;

  typedef enum logic [1:0] {ST_CLEAR, ST_IDLE, ST_SWEEP} eng_state_e;

  eng_state_e       state_q;
  logic [IDX_W-1:0] ptr_q;
  depth_e           depth_q;
  logic             upd_pend_q;
  logic [IDX_W-1:0] upd_idx_q;
  logic             s_valid_q;
  logic             s_sweep_q;
  logic [IDX_W-1:0] s_addr_q;
  logic             depth_diff;

  assign depth_diff  = depth_e'(depth_sel) != depth_q;
  assign comp_raddr  = upd_pend_q ? upd_idx_q : ptr_q;
  assign init_active = (state_q == ST_CLEAR);
  assign init_addr   = ptr_q;
  assign init_val    = (ptr_q == LAST) ? '1 : '0;
  assign busy        = (state_q != ST_IDLE) || s_sweep_q;

  always_comb begin
    if (init_active) begin
      pk_we    = 1'b1;
      pk_waddr = ptr_q;
      pk_wdata = pack_color(init_val, init_val, init_val, depth_q);
    end else begin
      pk_we    = s_valid_q;
      pk_waddr = s_addr_q;
      pk_wdata = pack_color(rd_comp[0], rd_comp[1], rd_comp[2], depth_q);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_CLEAR;
      ptr_q      <= '0;
      depth_q    <= DEPTH_8;
      upd_pend_q <= 1'b0;
      upd_idx_q  <= '0;
      s_valid_q  <= 1'b0;
      s_sweep_q  <= 1'b0;
      s_addr_q   <= '0;
    end else begin
      upd_pend_q <= host_we;
      if (host_we) upd_idx_q <= host_idx;
      s_valid_q <= 1'b0;
      s_sweep_q <= 1'b0;
      if (upd_pend_q) begin
        s_valid_q <= 1'b1;
        s_addr_q  <= upd_idx_q;
      end
      case (state_q)
        ST_CLEAR: begin
          ptr_q <= ptr_q + 1'b1;
          if (ptr_q == LAST) state_q <= ST_IDLE;
        end
        ST_IDLE: begin
          if (depth_diff) begin
            depth_q <= depth_e'(depth_sel);
            ptr_q   <= '0;
            state_q <= ST_SWEEP;
          end
        end
        default: begin
          if (depth_diff) begin
            depth_q <= depth_e'(depth_sel);
            ptr_q   <= '0;
          end else if (!upd_pend_q) begin
            s_valid_q <= 1'b1;
            s_sweep_q <= 1'b1;
            s_addr_q  <= ptr_q;
            ptr_q     <= ptr_q + 1'b1;
            if (ptr_q == LAST) state_q <= ST_IDLE;
          end
        end
      endcase
    end
  end

  // R9: a depth change seen while idle starts a rebuild at once
  a_r9_sweep_start: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && depth_diff) |=> busy);

  // R8: every pending entry update reaches the packed table next cycle
  a_r8_update_written: assert property (@(posedge clk) disable iff (rst)
    upd_pend_q |=> (pk_we && pk_waddr == $past(upd_idx_q)));

  // R6: the clear ends after the last entry
  a_r6_clear_exit: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_CLEAR && ptr_q == LAST) |=> (state_q == ST_IDLE));

  // R12: no host update is scheduled during the clear
  a_r12_no_host_in_clear: assert property (@(posedge clk) disable iff (rst)
    init_active |-> !host_we);

endmodule

// File: rtl/palette_dac.sv
module palette_dac
  import palette_dac_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_wr,
  input  logic [1:0]       bus_word,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic [1:0]       depth_sel,
  input  logic [IDX_W-1:0] pix_idx,
  output logic [PIX_W-1:0] pix_out,
  output logic             busy
);
  localparam int NCOMP = 3;

  logic                       cw_en;
  logic [1:0]                 cw_sel;
  logic [IDX_W-1:0]           cw_idx;
  logic [COMP_W-1:0]          cw_val;
  logic [NCOMP-1:0][COMP_W-1:0] comp_rd;
  logic [IDX_W-1:0]           comp_raddr;
  logic                       init_active;
  logic [IDX_W-1:0]           init_addr;
  logic [COMP_W-1:0]          init_val;
  logic                       pk_we;
  logic [IDX_W-1:0]           pk_waddr;
  logic [PIX_W-1:0]           pk_wdata;

  assign bus_rdata = '0;

  palette_dac_regs #(.IDX_W(IDX_W)) u_regs (
    .clk         (clk),
    .rst         (rst),
    .bus_wr      (bus_wr),
    .bus_word    (bus_word),
    .bus_wdata   (bus_wdata),
    .accept_data (!init_active),
    .cw_en       (cw_en),
    .cw_sel      (cw_sel),
    .cw_idx      (cw_idx),
    .cw_val      (cw_val)
  );

  for (genvar c = 0; c < NCOMP; c++) begin : g_comp
    logic              we_c;
    logic [IDX_W-1:0]  wa_c;
    logic [COMP_W-1:0] wd_c;
    assign we_c = init_active || (cw_en && (cw_sel == 2'(c)));
    assign wa_c = init_active ? init_addr : cw_idx;
    assign wd_c = init_active ? init_val  : cw_val;
    palette_dac_ram #(.W(COMP_W), .AW(IDX_W)) u_ram (
      .clk   (clk),
      .we    (we_c),
      .waddr (wa_c),
      .wdata (wd_c),
      .raddr (comp_raddr),
      .rdata (comp_rd[c])
    );
  end

  palette_dac_engine #(.IDX_W(IDX_W)) u_engine (
    .clk         (clk),
    .rst         (rst),
    .depth_sel   (depth_sel),
    .host_we     (cw_en),
    .host_idx    (cw_idx),
    .rd_comp     (comp_rd),
    .comp_raddr  (comp_raddr),
    .init_active (init_active),
    .init_addr   (init_addr),
    .init_val    (init_val),
    .pk_we       (pk_we),
    .pk_waddr    (pk_waddr),
    .pk_wdata    (pk_wdata),
    .busy        (busy)
  );

  palette_dac_ram #(.W(PIX_W), .AW(IDX_W)) u_packed (
    .clk   (clk),
    .we    (pk_we),
    .waddr (pk_waddr),
    .wdata (pk_wdata),
    .raddr (pix_idx),
    .rdata (pix_out)
  );

  // R1: the read port carries nothing but zero
  a_r1_read_zero: assert property (@(posedge clk) disable iff (rst)
    bus_wr |=> (bus_rdata == 32'd0));

endmodule

// File: tb/palette_dac_tb_top.sv
`timescale 1ns/1ps
module palette_dac_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_word = 2'd0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic [1:0]  depth_sel = 2'd0;
  logic [7:0]  pix_idx = 8'd0;
  logic [31:0] pix_out;
  logic        busy;

  int checks = 0;
  int errors = 0;

  int mr [256];
  int mg [256];
  int mb [256];
  int m_idx = 0;
  int m_ph  = 0;
  bit m_clear = 1'b0;

  always #2.5 clk = ~clk;

  palette_dac dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_word(bus_word),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .depth_sel(depth_sel),
    .pix_idx(pix_idx), .pix_out(pix_out), .busy(busy)
  );

  function automatic int exp_pack(int r, int g, int b, int d);
    case (d)
      1: return ((r / 8) * 1024) + ((g / 8) * 32) + (b / 8);
      2: return ((r / 8) * 2048) + ((g / 4) * 32) + (b / 8);
      3: return (r * 65536) + (g * 256) + b;
      default: return ((r / 32) * 32) + ((g / 32) * 4) + (b / 64);
    endcase
  endfunction

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // one register write; model follows the requirement text
  task automatic wr(input int word, input int data8);
    bus_wr    = 1'b1;
    bus_word  = 2'(word);
    bus_wdata = 32'(data8) << 24;
    @(posedge clk); #1;
    bus_wr = 1'b0;
    if (word == 0) begin
      m_idx = data8;
      m_ph  = 0;
    end else if (word == 1 && !m_clear) begin
      if (m_ph == 0) mr[m_idx] = data8;
      else if (m_ph == 1) mg[m_idx] = data8;
      else mb[m_idx] = data8;
      m_ph = (m_ph == 2) ? 0 : m_ph + 1;
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic lookup(input int i, output int v);
    pix_idx = 8'(i);
    @(posedge clk); #1;
    v = int'(pix_out);
  endtask

  task automatic sweep_check(input string tag, input int d);
    int v;
    for (int i = 0; i < 256; i++) begin
      lookup(i, v);
      check(tag, v, exp_pack(mr[i], mg[i], mb[i], d));
    end
  endtask

  task automatic entry_check(input string tag, input int i, input int d);
    int v;
    lookup(i, v);
    check(tag, v, exp_pack(mr[i], mg[i], mb[i], d));
  endtask

  task automatic count_busy(output int n);
    n = 0;
    for (int k = 0; k < 400; k++) begin
      @(posedge clk); #1;
      if (busy) n++;
      else break;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    int n, v, old;
    for (int i = 0; i < 256; i++) begin
      mr[i] = (i == 255) ? 255 : 0;
      mg[i] = mr[i];
      mb[i] = mr[i];
    end
    idle(3);
    rst = 1'b0;
    check("R6 busy after reset", busy, 1);
    check("R1 rdata after reset", bus_rdata, 0);

    // R12: data writes during the clear are dropped, index write kept
    m_clear = 1'b1;
    wr(0, 5);
    wr(1, 8'hAA);
    wr(1, 8'hBB);
    check("R12 still clearing", busy, 1);
    m_clear = 1'b0;
    count_busy(n);
    check("R6 clear finished", (n < 300) ? 1 : 0, 1);
    check("R6 busy low", busy, 0);
    sweep_check("R6 reset contents", 0);
    // phase stayed at red: next data write goes to red of entry 5
    wr(1, 8'hE0);
    idle(4);
    entry_check("R12 phase kept at red", 5, 0);

    // R3: fill the whole table with arithmetic colors
    for (int i = 0; i < 256; i++) begin
      wr(0, i);
      wr(1, (i * 37 + 11) % 256);
      wr(1, (i * 91 + 200) % 256);
      wr(1, (i * 13 + 77) % 256);
    end
    idle(4);
    sweep_check("R3 fill 8-bit", 0);
    check("R1 rdata after fill", bus_rdata, 0);

    // R9 and R7: each depth change rebuilds all entries
    for (int s = 0; s < 4; s++) begin
      int d;
      d = (s + 1) % 4;
      depth_sel = 2'(d);
      count_busy(n);
      check("R9 rebuild length low bound", (n >= 256) ? 1 : 0, 1);
      check("R9 rebuild length high bound", (n <= 260) ? 1 : 0, 1);
      sweep_check("R7 packing", d);
    end

    depth_sel = 2'd3;
    count_busy(n);
    check("R9 rebuild to 32-bit", (n >= 256 && n <= 260) ? 1 : 0, 1);

    // R8: each component shows up on its own
    wr(0, 16);
    wr(1, 8'hAB);
    idle(4);
    entry_check("R8 red only", 16, 3);
    wr(1, 8'h5C);
    idle(4);
    entry_check("R8 green only", 16, 3);
    wr(1, 8'h3E);
    idle(4);
    entry_check("R8 blue only", 16, 3);

    // R4: another triple rewrites the same entry
    wr(1, 8'h01);
    wr(1, 8'h02);
    wr(1, 8'h03);
    idle(4);
    entry_check("R4 same entry rewritten", 16, 3);
    entry_check("R4 neighbour untouched", 17, 3);

    // R5: offsets 8 and 12 ignored mid-triple
    wr(0, 16);
    wr(1, 8'h70);
    wr(2, 32);
    wr(3, 33);
    wr(1, 8'h71);
    idle(4);
    entry_check("R5 phase and index kept", 16, 3);
    entry_check("R5 entry 32 untouched", 32, 3);
    entry_check("R5 entry 33 untouched", 33, 3);

    // R2: index write mid-triple returns to red
    wr(0, 48);
    wr(1, 8'h11);
    wr(0, 48);
    wr(1, 8'h22);
    idle(4);
    entry_check("R2 phase reset to red", 48, 3);

    // R11 and R10: collision timing around a blue write
    wr(0, 64);
    wr(1, 8'h90);
    wr(1, 8'h91);
    idle(4);
    pix_idx   = 8'd64;
    old       = exp_pack(mr[64], mg[64], mb[64], 3);
    bus_wr    = 1'b1;
    bus_word  = 2'd1;
    bus_wdata = 32'h92 << 24;
    @(posedge clk); #1;
    bus_wr = 1'b0;
    mb[64] = 8'h92;
    m_ph   = 0;
    @(posedge clk); #1;
    check("R11 old before update", pix_out, old);
    @(posedge clk); #1;
    check("R11 old at same-edge collision", pix_out, old);
    @(posedge clk); #1;
    check("R10 new one edge later", pix_out, exp_pack(mr[64], mg[64], mb[64], 3));
    pix_idx = 8'd200;
    #1;
    check("R10 unchanged before edge", pix_out, exp_pack(mr[64], mg[64], mb[64], 3));
    @(posedge clk); #1;
    check("R10 one-cycle latency", pix_out, exp_pack(mr[200], mg[200], mb[200], 3));
    check("R1 rdata at end", bus_rdata, 0);

    finish_run();
  end

endmodule